// File: doc/BRIEF.md
# Banked Clock Fanout with Per-Bank Divide and Enable

This block takes one of two reference clocks and copies it onto sixteen output lines. The lines are grouped into four banks of four. Each bank has two controls of its own. The first picks whether the bank carries the reference clock unchanged or at half its frequency. The second is an enable that stops the bank cleanly, leaving its lines at a steady low. All four lines of a bank always carry the same level.

An active-low master control resets the block. While it is held low, it clears the shared divide-by-two flop and the captured enables, and it releases every output line to high impedance. Each line is modelled as a pair of signals: a level and a drive enable. A drive enable of zero stands for a released, high-impedance pin. Bank enables are sampled only on falling edges of the selected clock, so enabling or disabling a bank never produces a shortened pulse.

Top module: `banked_clk_fanout`

## Requirements
- R1: Output line `i` belongs to bank `i / 4`. Bank 0 is bits [3:0], bank 1 is bits [7:4], bank 2 is bits [11:8] and bank 3 is bits [15:12]. All four lines of a bank carry the same level at all times.
- R2: When `src_sel` is 1, `clk_b` is the reference clock. When it is 0, `clk_a` is the reference clock. Activity on the clock that is not selected has no effect on any output.
- R3: When `div_sel[b]` is 1, an enabled bank `b` follows the reference clock level. When it is 0, the bank carries the output of a toggle flop that flips on every rising reference edge. The first rising edge after reset release drives that flop high, so the bank runs at half the reference frequency.
- R4: Once a falling reference edge has sampled `bank_en[b]` as 0, bank `b` outputs a steady low while `mr_n` is 1.
- R5: While `mr_n` is 0, all sixteen `out_oe` bits are 0 (high impedance) and all `out_val` bits are 0. The divide-by-two flop and the captured enables are cleared, whatever the values of `div_sel` and `bank_en`.
- R6: `bank_en` is captured only on falling reference edges. While `mr_n` stays high, no output high or low pulse is shorter than half a reference period.
- R7: The divide-by-two flop keeps toggling while a bank is disabled. A re-enabled divide-by-two bank is therefore in phase with every other divide-by-two bank.
- R8: While `mr_n` is 1, all sixteen `out_oe` bits are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | First reference clock (single-ended source) |
| clk_b | input | 1 | Second reference clock (differential source seen as one logic level) |
| src_sel | input | 1 | Reference select: 1 picks clk_b, 0 picks clk_a |
| div_sel | input | 4 | Per-bank mode: 1 passes the clock through, 0 divides by two |
| bank_en | input | 4 | Per-bank enable, active high |
| mr_n | input | 1 | Active-low master reset and output release |
| out_val | output | 16 | Output line levels, four per bank |
| out_oe | output | 16 | Output line drive enables; 0 means high impedance |

## Verification
The bench builds the block with its default four banks of four lines. This makes an exhaustive sweep practical. It covers every one of the sixteen divide-mode patterns under both source selections, and under each it applies several enable patterns. Some of those enable changes land during the high phase of the reference and some during the low phase. An arithmetic model predicts every line in every half period, and a pulse-width monitor watches for runt pulses. Dedicated passes cover:
- edge counting for the frequency ratio,
- a disabled divide-by-two bank rejoining its neighbours in phase,
- toggling of the unselected clock,
- a reset asserted in the middle of a high phase.

// File: rtl/bcf_pkg.sv
package bcf_pkg;

    localparam int unsigned BANK_COUNT = 4;
    localparam int unsigned BANK_WIDTH = 4;

    typedef enum logic {
        DIV_BY_TWO = 1'b0,
        DIV_BY_ONE = 1'b1
    } div_mode_e;

    typedef struct packed {
        logic      run;
        div_mode_e mode;
    } bank_cfg_t;

    // Level a bank presents given its configuration and the two clock phases.
    function automatic logic bank_level(bank_cfg_t cfg, logic ref_clk, logic half_clk);
        logic src;
        src = (cfg.mode == DIV_BY_ONE) ? ref_clk : half_clk;
        return cfg.run & src;
    endfunction

endpackage

// File: rtl/bcf_clk_select.sv
module bcf_clk_select (
    input  logic clk_a,
    input  logic clk_b,
    input  logic src_sel,
    output logic ref_clk
);

    // Selection is expected to change only while the block is held in reset.
    assign ref_clk = src_sel ? clk_b : clk_a;

endmodule

// File: rtl/bcf_half_div.sv
module bcf_half_div (
    input  logic ref_clk,
    input  logic rst_n,
    output logic half_clk
);

    logic tgl_q;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl_q <= 1'b0;
        end else begin
            tgl_q <= ~tgl_q;
        end
    end

    assign half_clk = tgl_q;

    // R3: the divider flips on every rising reference edge while out of reset.
    p_toggle_every_rise_r3: assert property (
        @(posedge ref_clk) disable iff (!rst_n)
        1'b1 |=> (half_clk != $past(half_clk))
    );

endmodule

// File: rtl/bcf_bank.sv
module bcf_bank
    import bcf_pkg::*;
#(
    parameter int unsigned WIDTH = BANK_WIDTH
) (
    input  logic             ref_clk,
    input  logic             half_clk,
    input  logic             rst_n,
    input  logic             en_req,
    input  logic             div_sel,
    output logic [WIDTH-1:0] pin_val,
    output logic [WIDTH-1:0] pin_oe
);

    logic      en_q;
    bank_cfg_t cfg;
    logic      lvl;

    // Enable sampled on the falling edge: any change lands while the clock is low.
    always_ff @(negedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_req;
        end
    end

    always_comb begin
        cfg.run  = en_q;
        cfg.mode = div_mode_e'(div_sel);
        lvl      = bank_level(cfg, ref_clk, half_clk);
    end

    assign pin_val = {WIDTH{lvl}};
    assign pin_oe  = {WIDTH{rst_n}};

    // R4: a bank whose captured enable is low holds its lines low.
    p_park_low_r4: assert property (
        @(posedge ref_clk) disable iff (!rst_n)
        !en_q |-> (pin_val == '0)
    );

    // R1: all lines of the bank agree.
    p_bank_agree_r1: assert property (
        @(posedge ref_clk) disable iff (!rst_n)
        ($countones(pin_val) == 0) || ($countones(pin_val) == WIDTH)
    );

    // R8: lines are driven whenever the master control is inactive.
    p_drive_run_r8: assert property (
        @(posedge ref_clk) disable iff (!rst_n)
        1'b1 |-> (pin_oe == '1)
    );

    // R5: released lines carry no level while the master control is low.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            p_hiz_reset_r5: assert (pin_oe == '0 && pin_val == '0);
        end
    end

endmodule

// File: rtl/banked_clk_fanout.sv
module banked_clk_fanout
    import bcf_pkg::*;
#(
    parameter int unsigned NUM_BANKS = BANK_COUNT,
    parameter int unsigned BANK_OUTS = BANK_WIDTH,
    localparam int unsigned TOTAL_OUTS = NUM_BANKS * BANK_OUTS
) (
    input  logic                  clk_a,
    input  logic                  clk_b,
    input  logic                  src_sel,
    input  logic [NUM_BANKS-1:0]  div_sel,
    input  logic [NUM_BANKS-1:0]  bank_en,
    input  logic                  mr_n,
    output logic [TOTAL_OUTS-1:0] out_val,
    output logic [TOTAL_OUTS-1:0] out_oe
);

    logic ref_clk;
    logic half_clk;

    bcf_clk_select u_sel (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .src_sel (src_sel),
        .ref_clk (ref_clk)
    );

    // One divider shared by every bank keeps all divided banks in phase.
    bcf_half_div u_div (
        .ref_clk  (ref_clk),
        .rst_n    (mr_n),
        .half_clk (half_clk)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bcf_bank #(
            .WIDTH (BANK_OUTS)
        ) u_bank (
            .ref_clk  (ref_clk),
            .half_clk (half_clk),
            .rst_n    (mr_n),
            .en_req   (bank_en[b]),
            .div_sel  (div_sel[b]),
            .pin_val  (out_val[b*BANK_OUTS +: BANK_OUTS]),
            .pin_oe   (out_oe[b*BANK_OUTS +: BANK_OUTS])
        );
    end

endmodule

// File: tb/banked_clk_fanout_tb_top.sv
module banked_clk_fanout_tb_top;

    localparam int CLK_PERIOD = 20;
    localparam int Q          = CLK_PERIOD / 4;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int NB         = 4;
    localparam int BW         = 4;
    localparam int NO         = NB * BW;

    logic          clk_a = 1'b0;
    logic          clk_b = 1'b0;
    logic          src_sel = 1'b0;
    logic [NB-1:0] div_sel = '1;
    logic [NB-1:0] bank_en = '1;
    logic          mr_n = 1'b0;
    logic [NO-1:0] out_val;
    logic [NO-1:0] out_oe;

    int            n_chk = 0;
    int            n_bad = 0;
    logic [NB-1:0] en_m = '0;
    logic          div_m = 1'b0;
    logic          clk_lvl = 1'b0;
    int            unsel_cnt = 0;

    banked_clk_fanout dut_i (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .src_sel (src_sel),
        .div_sel (div_sel),
        .bank_en (bank_en),
        .mr_n    (mr_n),
        .out_val (out_val),
        .out_oe  (out_oe)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    function automatic logic [NO-1:0] exp_val();
        logic [NO-1:0] v;
        for (int b = 0; b < NB; b++) begin
            v[b*BW +: BW] = {BW{en_m[b] & (div_sel[b] ? clk_lvl : div_m)}};
        end
        return v;
    endfunction

    // One half period: move the selected clock, update the model, sample mid-phase.
    task automatic half(logic lvl, string tag);
        #Q;
        unsel_cnt++;
        if (src_sel) begin
            clk_b = lvl;
            clk_a = unsel_cnt[1];
        end else begin
            clk_a = lvl;
            clk_b = unsel_cnt[1];
        end
        clk_lvl = lvl;
        if (mr_n) begin
            if (lvl) div_m = ~div_m;
            else     en_m  = bank_en;
        end
        #Q;
        check(tag, {out_oe, out_val}, {(mr_n ? 16'hFFFF : 16'h0000), exp_val()});
    endtask

    task automatic cycles(int n, string tag);
        for (int i = 0; i < n; i++) begin
            half(1'b1, tag);
            half(1'b0, tag);
        end
    endtask

    // Runt monitor state (R6)
    time           last_t [NO];
    bit            last_ok[NO];
    logic [NO-1:0] prev_v = '0;

    task automatic do_reset(logic s, logic [NB-1:0] dm);
        mr_n = 1'b0;
        en_m = '0;
        div_m = 1'b0;
        for (int i = 0; i < NO; i++) last_ok[i] = 1'b0;
        #1;
        check("R5 reset entry", {out_oe, out_val}, 32'h0);
        clk_a   = 1'b0;
        clk_b   = 1'b0;
        clk_lvl = 1'b0;
        src_sel = s;
        div_sel = dm;
        cycles(2, "R5 held in reset");
        mr_n = 1'b1;
    endtask

    always @(out_val) begin
        for (int i = 0; i < NO; i++) begin
            if (out_val[i] !== prev_v[i]) begin
                if (!mr_n) begin
                    last_ok[i] = 1'b0;
                end else begin
                    if (last_ok[i]) begin
                        n_chk++;
                        if (($time - last_t[i]) < HALF) begin
                            n_bad++;
                            $display("FAIL R6 runt on line %0d: actual width=%0t expected>=%0d",
                                     i, $time - last_t[i], HALF);
                        end
                    end
                    last_ok[i] = 1'b1;
                    last_t[i]  = $time;
                end
            end
        end
        prev_v = out_val;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [NB-1:0] pat;
        logic [NB-1:0] prevlow;
        int            rc[NB];

        #1;
        check("R5 time zero", {out_oe, out_val}, 32'h0);

        // Sweep over every source select and divide-mode pattern (R1 R2 R3 R4 R6 R8)
        for (int s = 0; s < 2; s++) begin
            for (int dm = 0; dm < 16; dm++) begin
                bank_en = '1;
                do_reset(s[0], dm[3:0]);
                for (int ep = 0; ep < 4; ep++) begin
                    case (ep)
                        0: pat = 4'hF;
                        1: pat = dm[3:0] ^ 4'h5;
                        2: pat = ~dm[3:0];
                        default: pat = 4'h0;
                    endcase
                    half(1'b1, "R3 R4 sweep");
                    if (ep[0]) bank_en = pat;   // change during the high phase
                    half(1'b0, "R3 R4 sweep");
                    if (!ep[0]) bank_en = pat;  // change during the low phase
                    cycles(3, "R1 R3 R4 R6 sweep");
                end
            end
        end

        // R3: rising-edge count ratio per bank
        bank_en = '1;
        do_reset(1'b0, 4'b0101);
        cycles(1, "R3 warmup");
        for (int b = 0; b < NB; b++) begin
            prevlow[b] = out_val[b*BW];
            rc[b] = 0;
        end
        for (int i = 0; i < 8; i++) begin
            half(1'b1, "R3 count");
            for (int b = 0; b < NB; b++) if (out_val[b*BW] && !prevlow[b]) rc[b]++;
            half(1'b0, "R3 count");
            for (int b = 0; b < NB; b++) prevlow[b] = out_val[b*BW];
        end
        for (int b = 0; b < NB; b++) begin
            check("R3 edge ratio", rc[b], div_sel[b] ? 8 : 4);
        end

        // R2: unselected clock toggles with the selected one held low
        bank_en = '1;
        do_reset(1'b1, 4'hF);
        cycles(1, "R2 warmup");
        for (int i = 0; i < 4; i++) begin
            #Q;
            clk_a = ~clk_a;
            #Q;
            check("R2 unselected clock ignored", {out_oe, out_val}, {16'hFFFF, 16'h0000});
        end

        // R7: disabled divided bank rejoins in phase
        bank_en = '1;
        do_reset(1'b0, 4'b0000);
        cycles(2, "R7 run");
        bank_en = 4'b1110;
        cycles(3, "R7 bank0 off");
        half(1'b1, "R7");
        check("R4 bank0 parked", out_val[3:0], 4'h0);
        half(1'b0, "R7");
        bank_en = 4'b1111;
        cycles(2, "R7 rejoin");
        half(1'b1, "R7");
        check("R7 phase aligned high", out_val[3:0], out_val[7:4]);
        half(1'b0, "R7");
        half(1'b1, "R7");
        check("R7 phase aligned next", out_val[3:0], out_val[7:4]);

        // R5: reset asserted in the middle of a high phase
        do_reset(1'b0, 4'b1010);
        cycles(2, "R5 resume");
        half(1'b1, "R5");
        do_reset(1'b0, 4'b1010);
        cycles(2, "R5 after mid-high reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule